// File: doc/BRIEF.md
# Request-Triggered Single-Move Transfer Bank

This block holds eight small transfer channels that serve hardware service requests without running any software handler. A one-cycle pulse on a channel's request bit marks that channel pending. When the bank takes the channel, it moves one byte or one 16-bit word. It reads from the channel's source pointer, writes to its destination pointer, advances one of the two pointers and counts the channel's transfer budget down by one. While a move is in progress, `steal_o` is raised, so that the surrounding bus logic can hold the processor off for that slot.

When a channel's budget is exhausted (counter equal to zero), a further request moves no data. The bank forwards it as a one-cycle pulse on that channel's bit of `irq_o`, so the normal interrupt logic can take over. A counter loaded with all ones selects endless operation: that counter never changes, and the channel never forwards a request.

Channel settings are written through a plain write port, one field at a time. Field select 0 sets the source pointer, 1 the destination pointer and 2 the counter (low CW bits of the data). Field select 3 sets the mode: data bit 0 set means word moves, and data bit 1 set means the destination pointer advances (clear means the source pointer advances). A channel's settings must not be written while that channel is being served. The memory side is a valid/ready master. The bank raises `mem_valid` together with address, direction, size and write data, and holds all of them unchanged until `mem_ready` is high on a clock edge. Read data is taken from `mem_rdata` on the edge where a read is accepted.

Top module: `smb_top`

## Requirements
- R1: After reset, `mem_valid`, `steal_o`, `xfer_done` and every bit of `irq_o` are low, and every counter is zero.
- R2: A request pulse leaves its channel pending until the channel is served. If several channels are pending, the lowest-numbered one is served first, and the others stay pending and are served afterwards.
- R3: A move performs exactly one read at the source pointer and then exactly one write at the destination pointer. `mem_size` is 1 for a word and 0 for a byte. A byte write carries the byte read in bits 7:0 and zero in bits 15:8.
- R4: After each move, the selected pointer (source when mode bit 1 is clear, destination when it is set) grows by 2 for word mode and by 1 for byte mode. The other pointer keeps its value.
- R5: A move lowers a non-all-ones counter by one. A request taken while the counter is zero performs no memory access and gives exactly one `irq_o` pulse on that channel's bit.
- R6: A counter holding all ones never changes and never causes an `irq_o` pulse; every request on that channel moves data.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values on the next cycle.
- R8: One cycle after a write is accepted, `xfer_done` is high for one cycle and `done_ch` names the served channel. `xfer_done` is never high together with any `irq_o` bit.
- R9: `steal_o` is high from the cycle the read is offered until the write is accepted, and low when the bank is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NCH | Per-channel service request pulses |
| cfg_we | input | 1 | Settings write strobe |
| cfg_ch | input | CHW | Channel being written |
| cfg_sel | input | 2 | Field select: 0 source, 1 destination, 2 counter, 3 mode |
| cfg_wdata | input | AW | Field value |
| mem_valid | output | 1 | Memory access offered |
| mem_ready | input | 1 | Memory access accepted |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = word, 0 = byte |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken on read acceptance |
| steal_o | output | 1 | Bus slot taken by a move |
| irq_o | output | NCH | One-cycle forward of an exhausted channel's request |
| xfer_done | output | 1 | One-cycle pulse after each completed move |
| done_ch | output | CHW | Channel of the last completed move |

## Verification
The checker assumes that the memory side never withdraws data in a way that matters to the bank. `mem_rdata` only has to be valid on the accepting edge, and `mem_ready` may be low for any number of cycles. It also assumes that settings are never rewritten for the channel under service. The stimulus keeps to this: it writes settings only while the bank is idle, and drives read data as a pure function of the offered address. Back-pressure is applied by holding `mem_ready` low for several cycles in the middle of a service.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } smb_state_t;

  localparam logic [1:0] FLD_SRC  = 2'd0;
  localparam logic [1:0] FLD_DST  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;
  localparam logic [1:0] FLD_MODE = 2'd3;
endpackage

// File: rtl/smb_pending.sv
module smb_pending #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           clr_en,
  input  logic [CHW-1:0] clr_idx,
  output logic           any_o,
  output logic [CHW-1:0] gnt_o
);
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] clr_mask;

  assign clr_mask = clr_en ? (NCH'(1) << clr_idx) : '0;

  // a new request in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | req_i;
  end

  assign any_o = |pend_q;

  // lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) gnt_o = CHW'(i);
    end
  end
endmodule

// File: rtl/smb_chan_regs.sv
module smb_chan_regs
  import smb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           adv_en,
  input  logic [CHW-1:0] adv_ch,
  output logic [AW-1:0]  src_o  [NCH],
  output logic [AW-1:0]  dst_o  [NCH],
  output logic [CW-1:0]  cnt_o  [NCH],
  output logic           word_o [NCH],
  output logic           incd_o [NCH]
);
  localparam logic [CW-1:0] CNT_ENDLESS = {CW{1'b1}};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          hit_adv;
    logic          hit_cfg;
    logic [AW-1:0] step;

    assign hit_adv = adv_en && (adv_ch == CHW'(g));
    assign hit_cfg = cfg_we && (cfg_ch == CHW'(g));
    assign step    = word_o[g] ? AW'(2) : AW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_o[g]  <= '0;
        dst_o[g]  <= '0;
        cnt_o[g]  <= '0;
        word_o[g] <= 1'b0;
        incd_o[g] <= 1'b0;
      end else begin
        if (hit_adv) begin
          if (incd_o[g]) dst_o[g] <= dst_o[g] + step;
          else           src_o[g] <= src_o[g] + step;
          if (cnt_o[g] != CNT_ENDLESS) cnt_o[g] <= cnt_o[g] - CW'(1);
        end
        if (hit_cfg) begin
          case (cfg_sel)
            FLD_SRC:  src_o[g] <= cfg_wdata;
            FLD_DST:  dst_o[g] <= cfg_wdata;
            FLD_CNT:  cnt_o[g] <= cfg_wdata[CW-1:0];
            default: begin
              word_o[g] <= cfg_wdata[0];
              incd_o[g] <= cfg_wdata[1];
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend_any,
  input  logic [CHW-1:0] gnt_idx,
  input  logic           gnt_cnt_zero,
  input  logic [AW-1:0]  cur_src,
  input  logic [AW-1:0]  cur_dst,
  input  logic           cur_word,
  output logic [CHW-1:0] cur_ch,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_write,
  output logic           mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           clr_en,
  output logic [CHW-1:0] clr_idx,
  output logic           adv_en,
  output logic           busy_o,
  output logic [NCH-1:0] irq_o,
  output logic           done_o,
  output logic [CHW-1:0] done_ch
);
  localparam int BW = DW / 2;

  smb_state_t    st_q;
  logic [DW-1:0] data_q;
  logic          go_irq;
  logic          go_move;
  logic          rd_acc;
  logic          wr_acc;

  assign go_irq  = (st_q == ST_IDLE) && pend_any && gnt_cnt_zero;
  assign go_move = (st_q == ST_IDLE) && pend_any && !gnt_cnt_zero;
  assign rd_acc  = (st_q == ST_RD) && mem_ready;
  assign wr_acc  = (st_q == ST_WR) && mem_ready;

  assign mem_valid = (st_q != ST_IDLE);
  assign mem_write = (st_q == ST_WR);
  assign mem_size  = cur_word;
  assign mem_addr  = (st_q == ST_WR) ? cur_dst : cur_src;
  assign mem_wdata = data_q;
  assign busy_o    = (st_q != ST_IDLE);

  assign clr_en  = go_irq || wr_acc;
  assign clr_idx = go_irq ? gnt_idx : cur_ch;
  assign adv_en  = wr_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_ch  <= '0;
      data_q  <= '0;
      irq_o   <= '0;
      done_o  <= 1'b0;
      done_ch <= '0;
    end else begin
      irq_o  <= go_irq ? (NCH'(1) << gnt_idx) : '0;
      done_o <= wr_acc;
      if (wr_acc) done_ch <= cur_ch;
      case (st_q)
        ST_IDLE: if (go_move) begin
          cur_ch <= gnt_idx;
          st_q   <= ST_RD;
        end
        ST_RD: if (rd_acc) begin
          data_q <= cur_word ? mem_rdata : {{(DW-BW){1'b0}}, mem_rdata[BW-1:0]};
          st_q   <= ST_WR;
        end
        ST_WR: if (wr_acc) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_top.sv
module smb_top
  import smb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_write,
  output logic           mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           steal_o,
  output logic [NCH-1:0] irq_o,
  output logic           xfer_done,
  output logic [CHW-1:0] done_ch
);
  logic           pend_any;
  logic [CHW-1:0] gnt_idx;
  logic [CHW-1:0] cur_ch;
  logic           clr_en;
  logic [CHW-1:0] clr_idx;
  logic           adv_en;
  logic [AW-1:0]  src_a  [NCH];
  logic [AW-1:0]  dst_a  [NCH];
  logic [CW-1:0]  cnt_a  [NCH];
  logic           word_a [NCH];
  logic           incd_a [NCH];

  smb_pending #(.NCH(NCH), .CHW(CHW)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .any_o(pend_any), .gnt_o(gnt_idx)
  );

  smb_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .adv_en(adv_en), .adv_ch(cur_ch),
    .src_o(src_a), .dst_o(dst_a), .cnt_o(cnt_a), .word_o(word_a), .incd_o(incd_a)
  );

  smb_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CHW(CHW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .pend_any(pend_any), .gnt_idx(gnt_idx),
    .gnt_cnt_zero(cnt_a[gnt_idx] == '0),
    .cur_src(src_a[cur_ch]), .cur_dst(dst_a[cur_ch]), .cur_word(word_a[cur_ch]),
    .cur_ch(cur_ch),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .clr_en(clr_en), .clr_idx(clr_idx), .adv_en(adv_en),
    .busy_o(steal_o), .irq_o(irq_o), .done_o(xfer_done), .done_ch(done_ch)
  );
endmodule

// File: rtl/smb_chk.sv
module smb_chk #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_write,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           steal_o,
  input logic [NCH-1:0] irq_o,
  input logic           xfer_done
);
  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata));

  // R3
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> $past(mem_valid && !mem_write && mem_ready) || $past(mem_valid && mem_write && !mem_ready));

  // R5
  single_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(mem_valid && mem_write && mem_ready));

  // R8
  done_not_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && (irq_o != '0)));

  // R9
  steal_covers_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> steal_o);
endmodule

bind smb_top smb_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_smb_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .steal_o(steal_o), .irq_o(irq_o), .xfer_done(xfer_done)
);

// File: tb/test_smb_top.sv
module test_smb_top;
  localparam int NCH = 8;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam int CHW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0;
  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic           mem_valid, mem_write, mem_size, steal_o, xfer_done;
  logic           mem_ready = 1'b1;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata;
  logic [NCH-1:0] irq_o;
  logic [CHW-1:0] done_ch;

  int n_chk = 0, n_fail = 0;
  int wr_n = 0, rd_n = 0, done_n = 0;
  int irq_cnt [NCH];
  logic [AW-1:0] wr_a;
  logic [DW-1:0] wr_d;
  logic          wr_sz;
  bit            finished = 0;

  always #2 clk = ~clk;

  smb_top #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) i_smb_top (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .steal_o(steal_o), .irq_o(irq_o),
    .xfer_done(xfer_done), .done_ch(done_ch)
  );

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7 + 8'd3) ^ a[15:8];
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] s, input logic w);
    return w ? {fb(s + 16'd1), fb(s)} : {8'h00, fb(s)};
  endfunction

  assign mem_rdata = {fb(mem_addr + 16'd1), fb(mem_addr)};

  initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready && mem_write) begin
        wr_n  <= wr_n + 1;
        wr_a  <= mem_addr;
        wr_d  <= mem_wdata;
        wr_sz <= mem_size;
      end
      if (mem_valid && mem_ready && !mem_write) rd_n <= rd_n + 1;
      if (xfer_done) done_n <= done_n + 1;
      for (int i = 0; i < NCH; i++) if (irq_o[i]) irq_cnt[i] <= irq_cnt[i] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    @(negedge clk); req_i = m;
    @(negedge clk); req_i = '0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  // ch(3) word(1) inc_dst(1) src(16) dst(16) count(8)
  localparam logic [44:0] VEC [4] = '{
    {3'd0, 1'b0, 1'b0, 16'h0010, 16'h0100, 8'd2},
    {3'd2, 1'b1, 1'b1, 16'h0020, 16'h0200, 8'd2},
    {3'd5, 1'b1, 1'b0, 16'h0031, 16'h0300, 8'd2},
    {3'd7, 1'b0, 1'b1, 16'h0044, 16'h0400, 8'd2}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_valid && !steal_o && !xfer_done && irq_o == '0, "R1",
        {mem_valid, steal_o, xfer_done, irq_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: counters start at zero, so a request is forwarded at once
    fire(8'h40); settle();
    chk(irq_cnt[6] == 1 && wr_n == 0, "R1", irq_cnt[6], 1);

    for (int v = 0; v < 4; v++) begin
      logic [2:0] ch; logic w, d; logic [15:0] s, t, inc, a2, s2; logic [7:0] c;
      int n0, r0, i0, dn0;
      {ch, w, d, s, t, c} = VEC[v];
      inc = w ? 16'd2 : 16'd1;
      cfg(ch, 2'd0, s); cfg(ch, 2'd1, t); cfg(ch, 2'd2, {8'h00, c});
      cfg(ch, 2'd3, {14'h0, d, w});
      n0 = wr_n; r0 = rd_n; dn0 = done_n;
      fire(NCH'(1) << ch); settle();
      chk(wr_n == n0 + 1 && rd_n == r0 + 1, "R3 one read one write", wr_n - n0, 1);
      chk(wr_a == t && wr_sz == w, "R3 address/size", wr_a, t);
      chk(wr_d == exp_data(s, w), "R3 data", wr_d, exp_data(s, w));
      chk(done_n == dn0 + 1 && done_ch == ch, "R8 done", done_ch, ch);
      fire(NCH'(1) << ch); settle();
      a2 = d ? t + inc : t;
      s2 = d ? s : s + inc;
      chk(wr_a == a2, "R4 destination pointer", wr_a, a2);
      chk(wr_d == exp_data(s2, w), "R4 source pointer", wr_d, exp_data(s2, w));
      i0 = irq_cnt[ch]; n0 = wr_n;
      fire(NCH'(1) << ch); settle();
      chk(irq_cnt[ch] == i0 + 1, "R5 forward at zero", irq_cnt[ch] - i0, 1);
      chk(wr_n == n0, "R5 no access at zero", wr_n - n0, 0);
    end

    // R2 priority: channels 1 and 3 together
    begin
      int n0;
      cfg(1, 2'd0, 16'h0050); cfg(1, 2'd1, 16'h0A00); cfg(1, 2'd2, 16'd5); cfg(1, 2'd3, 16'd0);
      cfg(3, 2'd0, 16'h0060); cfg(3, 2'd1, 16'h0B00); cfg(3, 2'd2, 16'd5); cfg(3, 2'd3, 16'd0);
      n0 = wr_n;
      fire(8'b0000_1010);
      for (int k = 0; k < 20 && wr_n == n0; k++) @(negedge clk);
      chk(wr_a == 16'h0A00, "R2 lowest first", wr_a, 16'h0A00);
      settle();
      chk(wr_n == n0 + 2 && wr_a == 16'h0B00, "R2 other kept pending", wr_a, 16'h0B00);
    end

    // R6 endless counter
    begin
      int n0, i0;
      cfg(4, 2'd0, 16'h0070); cfg(4, 2'd1, 16'h0C00); cfg(4, 2'd2, 16'h00FF); cfg(4, 2'd3, 16'd0);
      n0 = wr_n; i0 = irq_cnt[4];
      for (int k = 0; k < 3; k++) begin fire(8'h10); settle(); end
      chk(wr_n == n0 + 3, "R6 every request moves", wr_n - n0, 3);
      chk(irq_cnt[4] == i0, "R6 no forward", irq_cnt[4] - i0, 0);
    end

    // R7/R9 back-pressure on channel 1 (source now 0x0051)
    begin
      int n0;
      n0 = wr_n;
      mem_ready = 1'b0;
      fire(8'h02);
      repeat (4) @(negedge clk);
      chk(mem_valid && !mem_write && mem_addr == 16'h0051, "R7 read held", mem_addr, 16'h0051);
      chk(steal_o == 1'b1, "R9 steal during service", steal_o, 1);
      mem_ready = 1'b1;
      settle();
      chk(steal_o == 1'b0 && wr_n == n0 + 1, "R9 released when idle", steal_o, 0);
      chk(wr_d == {8'h00, fb(16'h0051)}, "R7 data after stall", wr_d, {8'h00, fb(16'h0051)});
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule